// File: doc/BRIEF.md
# Flow Hit Destination Resolver

This block picks the exit ring for a received MSDU once the flow table lookup has finished. It takes the lookup outcome (hit or miss), the routing fields of the matched entry, two other candidate destinations (one from the address-search/peer path, one from the classifier super-rule), a first-fragment flag, a multi-buffer flag and a handful of configuration inputs. It returns a 5-bit ring ID, a tag that says which rule chose the ring, and the new value of the entry's stale-destination bit so the caller can write it back into the table.

The decision is built in layers. At the bottom, a 2-bit handler field chooses among the entry's own destination, the peer result and the super-rule result. Codes 7 and above then go through a programmable remap table. On top of that come the overrides. A miss uses a configured default ring. A drop bit forces the release ring. A stale-destination bit turns a hit into a routing miss. First-fragment marking sets that bit. PPE steering replaces the destination with a programmed ring, and this can be blocked for multi-buffer packets. The result is registered and comes with a valid strobe one cycle after the request.

Top module: `flow_dest_resolver`

## Requirements
- R1: While reset is held, and after it until the first request, out_valid, out_ring, out_src and out_rdi_bit are all zero.
- R2: out_valid is high in exactly the cycle after a cycle with req_valid high, and low otherwise.
- R3: On a hit with no override active, ent_handler 0 or 2 selects ent_dest (out_src 0), 1 selects peer_dest (out_src 1), and 3 selects rule_dest (out_src 2).
- R4: A handler-selected code below 7 is output unchanged. A code c of 7 or more is replaced by cfg_remap bits [5*(c-7)+4 : 5*(c-7)].
- R5: On a miss (lookup_hit low), out_ring equals cfg_miss_ring, out_src is 5, out_rdi_bit is 0, and the entry fields are ignored.
- R6: On a hit with ent_drop set, out_ring is 5 (release) and out_src is 3. This overrides every other source and override.
- R7: On a hit with ent_ppe set and no higher override, out_ring equals cfg_ppe_ring and out_src is 4, whatever the handler is.
- R8: When cfg_ppe_mb_block and multi_buf are both high, ent_ppe has no effect and the handler path decides.
- R9: With cfg_ff_mode high, a hit with first_frag high and ent_rdi_inval low gives out_ring = cfg_miss_ring, out_src 7 and out_rdi_bit 1.
- R10: A hit with ent_rdi_inval set and ent_drop clear gives out_ring = cfg_miss_ring, out_src 6 and out_rdi_bit 1.
- R11: On a hit that is neither first-fragment marked nor stale, out_rdi_bit is 0.
- R12: With req_valid low, out_ring, out_src and out_rdi_bit keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe; all other inputs are sampled with it |
| lookup_hit | input | 1 | Flow table lookup found an entry |
| ent_dest | input | 5 | Destination code stored in the entry |
| ent_handler | input | 2 | Handler select stored in the entry |
| ent_drop | input | 1 | Entry forces the release ring |
| ent_ppe | input | 1 | Entry requests PPE steering |
| ent_rdi_inval | input | 1 | Entry's stale-destination bit |
| peer_dest | input | 5 | Destination from the address-search/peer path |
| rule_dest | input | 5 | Destination from the classifier super-rule |
| first_frag | input | 1 | Packet is a first fragment |
| multi_buf | input | 1 | Packet spans more than one buffer |
| cfg_ff_mode | input | 1 | Enable first-fragment marking mode |
| cfg_ppe_mb_block | input | 1 | Block PPE steering for multi-buffer packets |
| cfg_ppe_ring | input | 5 | Ring ID used for PPE steering |
| cfg_miss_ring | input | 5 | Default ring ID for misses |
| cfg_remap | input | 125 | Remap table, 25 entries of 5 bits, for codes 7 to 31 |
| out_valid | output | 1 | Decision valid strobe |
| out_ring | output | 5 | Final ring ID |
| out_src | output | 3 | Which rule chose the ring (0 entry, 1 peer, 2 rule, 3 drop, 4 PPE, 5 miss, 6 stale, 7 first-fragment mark) |
| out_rdi_bit | output | 1 | New stale-destination bit for write-back |

## Verification
All state here is the single output register stage, so any fault shows up in the cycle right after the request that exposes it. A wrong override order shows as a wrong source tag paired with a plausible ring ID. A fault in the remap lookup shows only for codes 7 and above, and only through the handler path. A dropped or mistimed capture shows either as a valid strobe that is missing or late, or as outputs that change while no request is present. The tests therefore pair an override with each of the conditions below it, and they place request-free cycles between requests.

// File: rtl/frd_pkg.sv
// Package: shared encodings for the flow hit destination resolver.
// Assumes the source tag fits in three bits and the handler in two.
package frd_pkg;

    typedef enum logic [2:0] {
        SRC_ENTRY = 3'd0,
        SRC_PEER  = 3'd1,
        SRC_RULE  = 3'd2,
        SRC_DROP  = 3'd3,
        SRC_PPE   = 3'd4,
        SRC_MISS  = 3'd5,
        SRC_STALE = 3'd6,
        SRC_FRAG  = 3'd7
    } src_e;

    typedef enum logic [1:0] {
        HND_OWN_A = 2'd0,
        HND_PEER  = 2'd1,
        HND_OWN_B = 2'd2,
        HND_RULE  = 2'd3
    } hnd_e;

endpackage

// File: rtl/frd_handler_mux.sv
// Module: frd_handler_mux
// Chooses the base destination code from the entry, the peer path or the
// super-rule according to the handler select. Purely combinational.
// Assumes all candidate codes share the same width.
module frd_handler_mux #(
    parameter int RING_W = 5
) (
    input  logic [1:0]        handler,
    input  logic [RING_W-1:0] own_code,
    input  logic [RING_W-1:0] peer_code,
    input  logic [RING_W-1:0] rule_code,
    output logic [RING_W-1:0] code_out,
    output frd_pkg::src_e     src_out
);
    import frd_pkg::*;

    // Select the candidate code and tag it with its origin.
    always_comb begin
        case (hnd_e'(handler))
            HND_PEER: begin
                code_out = peer_code;
                src_out  = SRC_PEER;
            end
            HND_RULE: begin
                code_out = rule_code;
                src_out  = SRC_RULE;
            end
            default: begin
                code_out = own_code;
                src_out  = SRC_ENTRY;
            end
        endcase
    end

endmodule

// File: rtl/frd_remap.sv
// Module: frd_remap
// Passes codes below REMAP_BASE through unchanged and replaces higher codes
// with the matching entry of a flat programmable table. Combinational.
// Assumes table entry k serves code REMAP_BASE + k.
module frd_remap #(
    parameter int RING_W     = 5,
    parameter int REMAP_BASE = 7,
    localparam int CODES     = 1 << RING_W,
    localparam int REMAP_N   = CODES - REMAP_BASE
) (
    input  logic [RING_W-1:0]         code_in,
    input  logic [REMAP_N*RING_W-1:0] table_flat,
    output logic [RING_W-1:0]         code_out
);

    logic [RING_W-1:0] lut [CODES];

    // Build a full lookup over every code: identity below base, table above.
    for (genvar k = 0; k < CODES; k++) begin : g_lut
        if (k < REMAP_BASE) begin : g_pass
            assign lut[k] = RING_W'(k);
        end else begin : g_tbl
            assign lut[k] = table_flat[(k-REMAP_BASE)*RING_W +: RING_W];
        end
    end

    // Index the lookup with the incoming code.
    always_comb code_out = lut[code_in];

endmodule

// File: rtl/frd_override.sv
// Module: frd_override
// Layers the overrides on top of the handler result, highest first:
// miss, drop, stale destination, first-fragment marking, PPE steering.
// Also computes the stale-destination bit to write back.
// Assumes base_ring is already remapped.
module frd_override #(
    parameter int RING_W       = 5,
    parameter int RELEASE_CODE = 5
) (
    input  logic              hit,
    input  logic              drop,
    input  logic              ppe,
    input  logic              rdi_in,
    input  logic              first_frag,
    input  logic              multi_buf,
    input  logic              ff_mode,
    input  logic              ppe_mb_block,
    input  logic [RING_W-1:0] ppe_ring,
    input  logic [RING_W-1:0] miss_ring,
    input  logic [RING_W-1:0] base_ring,
    input  frd_pkg::src_e     base_src,
    output logic [RING_W-1:0] ring_out,
    output frd_pkg::src_e     src_out,
    output logic              rdi_out
);
    import frd_pkg::*;

    logic frag_mark;
    logic ppe_allowed;

    // Qualify the first-fragment marking and the PPE steering conditions.
    always_comb begin
        frag_mark   = hit && ff_mode && first_frag && !rdi_in;
        ppe_allowed = ppe && !(ppe_mb_block && multi_buf);
    end

    // Apply the override ladder in priority order.
    always_comb begin
        if (!hit) begin
            ring_out = miss_ring;
            src_out  = SRC_MISS;
        end else if (drop) begin
            ring_out = RING_W'(RELEASE_CODE);
            src_out  = SRC_DROP;
        end else if (rdi_in) begin
            ring_out = miss_ring;
            src_out  = SRC_STALE;
        end else if (frag_mark) begin
            ring_out = miss_ring;
            src_out  = SRC_FRAG;
        end else if (ppe_allowed) begin
            ring_out = ppe_ring;
            src_out  = SRC_PPE;
        end else begin
            ring_out = base_ring;
            src_out  = base_src;
        end
    end

    // Stale-destination bit for write-back: sticky once set, zero on miss.
    always_comb rdi_out = hit && (rdi_in || frag_mark);

endmodule

// File: rtl/flow_dest_resolver.sv
// Module: flow_dest_resolver (top)
// Resolves the exit ring of a received MSDU from a flow lookup result and
// registers the decision with a valid strobe one cycle after req_valid.
// Assumes all inputs are stable and meaningful while req_valid is high.
module flow_dest_resolver #(
    parameter int RING_W       = 5,
    parameter int REMAP_BASE   = 7,
    parameter int RELEASE_CODE = 5,
    localparam int REMAP_N     = (1 << RING_W) - REMAP_BASE,
    localparam int TBL_W       = REMAP_N * RING_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              lookup_hit,
    input  logic [RING_W-1:0] ent_dest,
    input  logic [1:0]        ent_handler,
    input  logic              ent_drop,
    input  logic              ent_ppe,
    input  logic              ent_rdi_inval,
    input  logic [RING_W-1:0] peer_dest,
    input  logic [RING_W-1:0] rule_dest,
    input  logic              first_frag,
    input  logic              multi_buf,
    input  logic              cfg_ff_mode,
    input  logic              cfg_ppe_mb_block,
    input  logic [RING_W-1:0] cfg_ppe_ring,
    input  logic [RING_W-1:0] cfg_miss_ring,
    input  logic [TBL_W-1:0]  cfg_remap,
    output logic              out_valid,
    output logic [RING_W-1:0] out_ring,
    output logic [2:0]        out_src,
    output logic              out_rdi_bit
);
    import frd_pkg::*;

    logic [RING_W-1:0] hnd_code;
    src_e              hnd_src;
    logic [RING_W-1:0] mapped_code;
    logic [RING_W-1:0] next_ring;
    src_e              next_src;
    logic              next_rdi;

    frd_handler_mux #(.RING_W(RING_W)) u_hmux (
        .handler   (ent_handler),
        .own_code  (ent_dest),
        .peer_code (peer_dest),
        .rule_code (rule_dest),
        .code_out  (hnd_code),
        .src_out   (hnd_src)
    );

    frd_remap #(.RING_W(RING_W), .REMAP_BASE(REMAP_BASE)) u_remap (
        .code_in    (hnd_code),
        .table_flat (cfg_remap),
        .code_out   (mapped_code)
    );

    frd_override #(.RING_W(RING_W), .RELEASE_CODE(RELEASE_CODE)) u_ovr (
        .hit          (lookup_hit),
        .drop         (ent_drop),
        .ppe          (ent_ppe),
        .rdi_in       (ent_rdi_inval),
        .first_frag   (first_frag),
        .multi_buf    (multi_buf),
        .ff_mode      (cfg_ff_mode),
        .ppe_mb_block (cfg_ppe_mb_block),
        .ppe_ring     (cfg_ppe_ring),
        .miss_ring    (cfg_miss_ring),
        .base_ring    (mapped_code),
        .base_src     (hnd_src),
        .ring_out     (next_ring),
        .src_out      (next_src),
        .rdi_out      (next_rdi)
    );

    // Valid strobe follows the request by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= req_valid;
    end

    // Capture the decision on a request and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_ring    <= '0;
            out_src     <= '0;
            out_rdi_bit <= 1'b0;
        end else if (req_valid) begin
            out_ring    <= next_ring;
            out_src     <= next_src;
            out_rdi_bit <= next_rdi;
        end
    end

endmodule

// File: rtl/frd_checker.sv
// Module: frd_checker
// Port-level temporal checks for flow_dest_resolver, bound to every instance.
module frd_checker #(
    parameter int RING_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              lookup_hit,
    input logic              ent_drop,
    input logic              ent_ppe,
    input logic              ent_rdi_inval,
    input logic              first_frag,
    input logic              multi_buf,
    input logic              cfg_ff_mode,
    input logic              cfg_ppe_mb_block,
    input logic [RING_W-1:0] cfg_miss_ring,
    input logic              out_valid,
    input logic [RING_W-1:0] out_ring,
    input logic [2:0]        out_src,
    input logic              out_rdi_bit
);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);                                           // R2
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid);                                         // R2
    AST_MISS_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !lookup_hit) |=>
        (out_ring == $past(cfg_miss_ring) && out_src == 3'd5 && !out_rdi_bit)); // R5
    AST_DROP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && lookup_hit && ent_drop) |=>
        (out_ring == RING_W'(5) && out_src == 3'd3));                       // R6
    AST_PPE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && lookup_hit && ent_ppe && cfg_ppe_mb_block && multi_buf) |=>
        (out_src != 3'd4));                                                 // R8
    AST_STALE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && lookup_hit && !ent_drop && ent_rdi_inval) |=>
        (out_src == 3'd6 && out_rdi_bit));                                  // R10
    AST_FRAG_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && lookup_hit && !ent_drop && !ent_rdi_inval && cfg_ff_mode && first_frag) |=>
        (out_src == 3'd7 && out_rdi_bit));                                  // R9
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(out_ring) && $stable(out_src) && $stable(out_rdi_bit))); // R12

endmodule

bind flow_dest_resolver frd_checker #(.RING_W(RING_W)) u_frd_chk (.*);

// File: tb/tb_flow_dest_resolver.sv
`timescale 1ns/1ps
module tb_flow_dest_resolver;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         lookup_hit = 1'b0;
    logic [4:0]   ent_dest = '0;
    logic [1:0]   ent_handler = '0;
    logic         ent_drop = 1'b0;
    logic         ent_ppe = 1'b0;
    logic         ent_rdi_inval = 1'b0;
    logic [4:0]   peer_dest = '0;
    logic [4:0]   rule_dest = '0;
    logic         first_frag = 1'b0;
    logic         multi_buf = 1'b0;
    logic         cfg_ff_mode = 1'b0;
    logic         cfg_ppe_mb_block = 1'b0;
    logic [4:0]   cfg_ppe_ring = 5'd12;
    logic [4:0]   cfg_miss_ring = 5'd9;
    logic [124:0] cfg_remap;
    logic         out_valid;
    logic [4:0]   out_ring;
    logic [2:0]   out_src;
    logic         out_rdi_bit;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    flow_dest_resolver dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .lookup_hit(lookup_hit),
        .ent_dest(ent_dest), .ent_handler(ent_handler), .ent_drop(ent_drop),
        .ent_ppe(ent_ppe), .ent_rdi_inval(ent_rdi_inval), .peer_dest(peer_dest),
        .rule_dest(rule_dest), .first_frag(first_frag), .multi_buf(multi_buf),
        .cfg_ff_mode(cfg_ff_mode), .cfg_ppe_mb_block(cfg_ppe_mb_block),
        .cfg_ppe_ring(cfg_ppe_ring), .cfg_miss_ring(cfg_miss_ring),
        .cfg_remap(cfg_remap), .out_valid(out_valid), .out_ring(out_ring),
        .out_src(out_src), .out_rdi_bit(out_rdi_bit)
    );

    // Remap table: code c (7..31) maps to 38 - c.
    initial begin
        for (int k = 0; k < 25; k++) cfg_remap[k*5 +: 5] = 5'(31 - k);
    end

    task automatic check3(input string req, input logic [4:0] ring,
                          input logic [2:0] src, input logic rdi);
        checks++;
        if (out_ring !== ring || out_src !== src || out_rdi_bit !== rdi) begin
            errors++;
            $display("FAIL %s: ring/src/rdi actual %0d/%0d/%0d expected %0d/%0d/%0d",
                     req, out_ring, out_src, out_rdi_bit, ring, src, rdi);
        end
    endtask

    task automatic check_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    // Issue one request and check the registered decision one cycle later.
    task automatic req(input logic hit, input logic [1:0] hnd, input logic [4:0] dst,
                       input logic drop, input logic ppe, input logic rdi,
                       input logic ff, input logic mb, input string tag,
                       input logic [4:0] e_ring, input logic [2:0] e_src, input logic e_rdi);
        @(negedge clk);
        lookup_hit = hit; ent_handler = hnd; ent_dest = dst; ent_drop = drop;
        ent_ppe = ppe; ent_rdi_inval = rdi; first_frag = ff; multi_buf = mb;
        req_valid = 1'b1;
        @(posedge clk); #1;
        check_bit({tag, " valid"}, out_valid, 1'b1);
        check3(tag, e_ring, e_src, e_rdi);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check_bit("R1 valid", out_valid, 1'b0);
        check3("R1 reset", 5'd0, 3'd0, 1'b0);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;
        check_bit("R1 valid after release", out_valid, 1'b0);
    endtask

    task automatic t_handler();
        peer_dest = 5'd4; rule_dest = 5'd2;
        req(1, 2'd0, 5'd3, 0, 0, 0, 0, 0, "R3 hnd0", 5'd3, 3'd0, 1'b0);
        req(1, 2'd2, 5'd6, 0, 0, 0, 0, 0, "R3 hnd2", 5'd6, 3'd0, 1'b0);
        req(1, 2'd1, 5'd3, 0, 0, 0, 0, 0, "R3 hnd1", 5'd4, 3'd1, 1'b0);
        req(1, 2'd3, 5'd3, 0, 0, 0, 0, 0, "R3 hnd3", 5'd2, 3'd2, 1'b0);
    endtask

    task automatic t_remap();
        req(1, 2'd0, 5'd7,  0, 0, 0, 0, 0, "R4 code7",  5'd31, 3'd0, 1'b0);
        req(1, 2'd0, 5'd10, 0, 0, 0, 0, 0, "R4 code10", 5'd28, 3'd0, 1'b0);
        req(1, 2'd2, 5'd31, 0, 0, 0, 0, 0, "R4 code31", 5'd7,  3'd0, 1'b0);
        peer_dest = 5'd20;
        req(1, 2'd1, 5'd0,  0, 0, 0, 0, 0, "R4 peer20", 5'd18, 3'd1, 1'b0);
        rule_dest = 5'd6;
        req(1, 2'd3, 5'd0,  0, 0, 0, 0, 0, "R4 rule6",  5'd6,  3'd2, 1'b0);
    endtask

    task automatic t_miss();
        req(0, 2'd0, 5'd3, 1, 1, 1, 1, 0, "R5 miss", 5'd9, 3'd5, 1'b0);
        cfg_miss_ring = 5'd17;
        req(0, 2'd1, 5'd3, 0, 0, 0, 0, 0, "R5 miss ring17", 5'd17, 3'd5, 1'b0);
        cfg_miss_ring = 5'd9;
    endtask

    task automatic t_drop();
        req(1, 2'd1, 5'd3, 1, 1, 0, 0, 0, "R6 drop over ppe", 5'd5, 3'd3, 1'b0);
        req(1, 2'd0, 5'd3, 1, 0, 1, 0, 0, "R6 drop over stale", 5'd5, 3'd3, 1'b1);
    endtask

    task automatic t_ppe();
        rule_dest = 5'd2;
        req(1, 2'd3, 5'd3, 0, 1, 0, 0, 0, "R7 ppe", 5'd12, 3'd4, 1'b0);
        cfg_ppe_mb_block = 1'b1;
        req(1, 2'd3, 5'd3, 0, 1, 0, 0, 0, "R7 block single buf", 5'd12, 3'd4, 1'b0);
        req(1, 2'd3, 5'd3, 0, 1, 0, 0, 1, "R8 blocked multi buf", 5'd2, 3'd2, 1'b0);
        cfg_ppe_mb_block = 1'b0;
        req(1, 2'd3, 5'd3, 0, 1, 0, 0, 1, "R8 unblocked multi buf", 5'd12, 3'd4, 1'b0);
    endtask

    task automatic t_frag();
        cfg_ff_mode = 1'b1;
        req(1, 2'd0, 5'd2, 0, 1, 0, 1, 0, "R9 mark", 5'd9, 3'd7, 1'b1);
        req(1, 2'd0, 5'd2, 0, 0, 0, 0, 0, "R11 mode no frag", 5'd2, 3'd0, 1'b0);
        cfg_ff_mode = 1'b0;
        req(1, 2'd0, 5'd2, 0, 0, 0, 1, 0, "R11 frag no mode", 5'd2, 3'd0, 1'b0);
    endtask

    task automatic t_stale();
        req(1, 2'd0, 5'd2, 0, 1, 1, 0, 0, "R10 stale", 5'd9, 3'd6, 1'b1);
        cfg_ff_mode = 1'b1;
        req(1, 2'd1, 5'd2, 0, 0, 1, 1, 0, "R10 stale with frag", 5'd9, 3'd6, 1'b1);
        cfg_ff_mode = 1'b0;
    endtask

    task automatic t_strobe_hold();
        req(1, 2'd0, 5'd3, 0, 0, 0, 0, 0, "R2 strobe", 5'd3, 3'd0, 1'b0);
        @(posedge clk); #1;
        check_bit("R2 strobe drops", out_valid, 1'b0);
        @(negedge clk);
        lookup_hit = 1'b0; ent_dest = 5'd8; ent_drop = 1'b1; ent_rdi_inval = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check3("R12 hold", 5'd3, 3'd0, 1'b0);
        check_bit("R2 idle", out_valid, 1'b0);
    endtask

    initial begin
        t_reset();
        t_handler();
        t_remap();
        t_miss();
        t_drop();
        t_ppe();
        t_frag();
        t_stale();
        t_strobe_hold();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule